// File: doc/BRIEF.md
# Delay Code Loader

This block keeps the 8-bit code that selects the tap of a programmable delay element, and offers three ways of changing it. With the mode pin high, the code is taken from an 8-bit parallel bus. While the enable is high the code follows the bus, and when the enable falls the bus value is frozen. With the mode pin low, a serial shift register is filled one bit per rising edge of a shift clock while the enable is high. The previous contents leave on a serial output at the same time. When the enable falls, the shift register becomes the new active code.

The serial output carries a separate output-enable flag, which is high only in serial mode while the enable is high, so that several loaders can be daisy-chained. Each loader's serial output feeds the next loader's serial input, and all loaders share the enable and the shift clock. The enable, shift clock and serial data inputs are asynchronous. They are resynchronized to the system clock, and all edges are detected in that clock domain. The mode pin and the parallel bus are sampled directly and must be quasi-static. Every interface here is a plain control or data pin. No input is a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `dly_setting_port`

## Requirements
- R1: After reset, the active code `dly_code` is 0, the shift register is 0 (so a first serial read returns 0), and `sdo_oe` is 0.
- R2: With `mode_par`=1 and the synchronized enable high, `dly_code` takes the value of `par_in` at every clock edge, so a bus change is visible one edge later. Bit 7 is the most significant bit.
- R3: With `mode_par`=1, a falling enable captures `par_in` into `dly_code`. After that, `par_in` changes have no effect while the enable stays low.
- R4: With `mode_par`=0 and the enable high, each rising edge of `sclk_in` shifts `sdi_in` into bit 0 and moves every other bit one place toward bit 7, so a code is sent MSB first. `dly_code` does not change while shifting.
- R5: `sdo` always shows bit 7 of the shift register. When the enable rises in serial mode, the old MSB is therefore visible before any shift clock. `sdo_oe` is 1 exactly when `mode_par`=0 and the synchronized enable is high.
- R6: With `mode_par`=0, a falling enable copies the shift register into `dly_code`.
- R7: A serial read is destructive: the old bits are replaced as they leave. Shifting the read bits back in before the enable falls keeps the code unchanged.
- R8: Shift clock edges that arrive while the enable is low leave the shift register unchanged.
- R9: In a chain of N loaders, 8·N bits are shifted as MSB-first bytes. The first byte sent ends up in the last loader of the chain.
- R10: A parallel load (transparent or captured) also writes the shift register, so a later serial read returns the active code.
- R11: Each change on `en_in`, `sclk_in` or `sdi_in` acts at the third rising clock edge that follows it. For example, `dly_code` updates on the third edge after `en_in` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_par | input | 1 | 1 selects parallel loading, 0 selects serial loading |
| en_in | input | 1 | Load enable, asynchronous |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| sdi_in | input | 1 | Serial data in, asynchronous |
| par_in | input | W | Parallel code bus |
| dly_code | output | W | Active delay code |
| sdo | output | 1 | Serial data out (shift register MSB) |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The bench first reads a captured parallel value serially while writing a new code. Here a loader that did not load the shift register on parallel writes, or that shifted LSB first, would return the wrong old bits. It samples the code exactly two and three edges after the enable falls, which catches a commit that lands one cycle early or late. It also pulses the shift clock while the enable is low. A loader that ignored the enable would lose its code, and this shows up in the read-back that follows. Two chained loaders take 16 bits, and a wrong shift order or a wrong synchronizer alignment would swap the bytes or skew them by one bit.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int unsigned CODE_W     = 8;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    SR_HOLD  = 2'd0,
    SR_LOAD  = 2'd1,
    SR_SHIFT = 2'd2
  } sr_op_e;
endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
  parameter int unsigned N     = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [DEPTH-1:0][N-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < DEPTH; i++) begin
        stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/dsp_edge.sv
module dsp_edge #(
  parameter int unsigned N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] d_prev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_prev <= '0;
    else        d_prev <= d;
  end
endmodule

// File: rtl/dsp_shreg.sv
module dsp_shreg
  import dsp_pkg::*;
#(
  parameter int unsigned W = CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sr_op_e       op,
  input  logic [W-1:0] load_val,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      case (op)
        SR_LOAD:  q <= load_val;
        SR_SHIFT: q <= {q[W-2:0], sin};
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/dsp_hold.sv
module dsp_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_bus,
  input  logic [W-1:0] bus_val,
  input  logic         take_reg,
  input  logic [W-1:0] reg_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (take_bus) q <= bus_val;
    else if (take_reg) q <= reg_val;
  end
endmodule

// File: rtl/dly_setting_port.sv
module dly_setting_port
  import dsp_pkg::*;
#(
  parameter int unsigned W           = CODE_W,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_par,
  input  logic         en_in,
  input  logic         sclk_in,
  input  logic         sdi_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] dly_code,
  output logic         sdo,
  output logic         sdo_oe
);
  localparam int unsigned NSYNC = 3;
  localparam int unsigned IX_EN = 0;
  localparam int unsigned IX_SC = 1;
  localparam int unsigned IX_SD = 2;
  localparam int unsigned NEDGE = IX_SC + 1;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] synced;
  logic [NEDGE-1:0] edge_prev;

  logic en_s, en_d, sclk_s, sclk_d, sdi_s;
  logic en_fall, sclk_rise;
  logic ser_mode, take_bus, take_reg;
  sr_op_e sr_op;
  logic [W-1:0] shreg_q;

  assign raw_in[IX_EN] = en_in;
  assign raw_in[IX_SC] = sclk_in;
  assign raw_in[IX_SD] = sdi_in;

  dsp_sync #(.N(NSYNC), .DEPTH(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
  );

  dsp_edge #(.N(NEDGE)) u_edge (
    .clk(clk), .rst_n(rst_n), .d(synced[NEDGE-1:0]), .d_prev(edge_prev)
  );

  assign en_s      = synced[IX_EN];
  assign sclk_s    = synced[IX_SC];
  assign sdi_s     = synced[IX_SD];
  assign en_d      = edge_prev[IX_EN];
  assign sclk_d    = edge_prev[IX_SC];
  assign en_fall   = en_d & ~en_s;
  assign sclk_rise = sclk_s & ~sclk_d;

  assign ser_mode = ~mode_par;
  assign take_bus = mode_par & (en_s | en_fall);
  assign take_reg = ser_mode & en_fall;

  always_comb begin
    if (take_bus)                      sr_op = SR_LOAD;
    else if (ser_mode & en_s & sclk_rise) sr_op = SR_SHIFT;
    else                               sr_op = SR_HOLD;
  end

  dsp_shreg #(.W(W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .op(sr_op), .load_val(par_in),
    .sin(sdi_s), .q(shreg_q)
  );

  dsp_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .take_bus(take_bus), .bus_val(par_in),
    .take_reg(take_reg), .reg_val(shreg_q), .q(dly_code)
  );

  assign sdo    = shreg_q[W-1];
  assign sdo_oe = ser_mode & en_s;
endmodule

// File: rtl/dly_setting_port_chk.sv
module dly_setting_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_par,
  input logic [W-1:0] par_in,
  input logic [W-1:0] dly_code,
  input logic         en_sync,
  input logic         en_fall,
  input logic         sclk_rise,
  input logic         sdi_sync,
  input logic [W-1:0] shreg
);
  p_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_par && en_sync) |=> (dly_code == $past(par_in)));

  p_hold_low_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_sync && !en_fall) |=> $stable(dly_code));

  p_no_commit_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_par && en_sync) |=> $stable(dly_code));

  p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_par && en_sync && sclk_rise) |=>
      (shreg == {$past(shreg[W-2:0]), $past(sdi_sync)}));

  p_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_par && en_fall) |=> (dly_code == $past(shreg)));

  p_idle_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_par && !en_sync) |=> $stable(shreg));
endmodule

bind dly_setting_port dly_setting_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .par_in(par_in),
  .dly_code(dly_code), .en_sync(en_s), .en_fall(en_fall),
  .sclk_rise(sclk_rise), .sdi_sync(sdi_s), .shreg(shreg_q)
);

// File: tb/dly_setting_port_test.sv
module dly_setting_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_par = 1'b0;
  logic       en_in = 1'b0;
  logic       sclk_in = 1'b0;
  logic       sdi_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic [7:0] dly_code, dly_code_b;
  logic       sdo, sdo_oe, sdo_b, sdo_oe_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_setting_port uut (
    .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .en_in(en_in),
    .sclk_in(sclk_in), .sdi_in(sdi_in), .par_in(par_in),
    .dly_code(dly_code), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  dly_setting_port uut_b (
    .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .en_in(en_in),
    .sclk_in(sclk_in), .sdi_in(sdo), .par_in(par_in),
    .dly_code(dly_code_b), .sdo(sdo_b), .sdo_oe(sdo_oe_b)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: input history queues, integer state
  bit en_q[$], sc_q[$], sd_q[$];
  int m_code, m_reg;
  bit cur_en, prev_en, cur_sc, prev_sc, cur_sd;

  always @(posedge clk) begin
    if (!rst_n) begin
      en_q = {1'b0, 1'b0, 1'b0};
      sc_q = {1'b0, 1'b0, 1'b0};
      sd_q = {1'b0, 1'b0};
      m_code = 0;
      m_reg  = 0;
    end else begin
      // index 0 newest sample, 1 synchronized, 2 previous synchronized
      cur_en = en_q[1]; prev_en = en_q[2];
      cur_sc = sc_q[1]; prev_sc = sc_q[2];
      cur_sd = sd_q[1];
      if (mode_par) begin
        if (cur_en || (prev_en && !cur_en)) begin
          m_code = par_in;
          m_reg  = par_in;
        end
      end else begin
        if (cur_en && cur_sc && !prev_sc) m_reg = ((m_reg << 1) | cur_sd) & 255;
        if (prev_en && !cur_en) m_code = m_reg;
      end
      en_q.push_front(en_in);   void'(en_q.pop_back());
      sc_q.push_front(sclk_in); void'(sc_q.pop_back());
      sd_q.push_front(sdi_in);  void'(sd_q.pop_back());
    end
    #(CLK_PERIOD/4);
    if (rst_n) begin
      chk("model dly_code R2 R3 R4 R6", dly_code, m_code);
      chk("model sdo R5 R7", sdo, (m_reg >> 7) & 1);
      chk("model sdo_oe R5", sdo_oe, (!mode_par && en_q[1]) ? 1 : 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit b);
    sdi_in = b;
    sclk_in = 1'b1;
    tick(4);
    sclk_in = 1'b0;
    tick(4);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R11 actual=running expected=finished");
      report();
    end
  end

  initial begin
    bit [7:0] old_v, new_v;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 code after reset", dly_code, 0);
    chk("R1 oe after reset", sdo_oe, 0);
    mode_par = 1'b0; en_in = 1'b1;
    tick(4);
    chk("R1 reg msb after reset", sdo, 0);
    chk("R5 oe in serial", sdo_oe, 1);
    en_in = 1'b0;
    tick(4);
    chk("R1 commit of zero reg", dly_code, 0);

    // R2 transparent
    mode_par = 1'b1; par_in = 8'h5A; en_in = 1'b1;
    tick(4);
    chk("R2 follow bus", dly_code, 8'h5A);
    par_in = 8'hC3;
    tick(1);
    chk("R2 one edge latency", dly_code, 8'hC3);
    chk("R5 oe low in parallel", sdo_oe, 0);

    // R3 capture on fall
    par_in = 8'hA5;
    tick(1);
    en_in = 1'b0;
    tick(4);
    chk("R3 captured", dly_code, 8'hA5);
    par_in = 8'hFF;
    tick(3);
    chk("R3 bus ignored", dly_code, 8'hA5);

    // R10 / R5 / R4 serial read-while-write
    mode_par = 1'b0; en_in = 1'b1;
    tick(4);
    chk("R5 old msb before clock", sdo, 1);
    old_v = 8'hA5; new_v = 8'h96;
    for (int k = 0; k < 8; k++) begin
      chk("R10 R7 read old bit", sdo, old_v[7-k]);
      pulse(new_v[7-k]);
    end
    chk("R4 code stable while shifting", dly_code, 8'hA5);
    chk("R4 msb first", sdo, 1);

    // R6 / R11 commit timing
    en_in = 1'b0;
    tick(2);
    chk("R11 not yet at second edge", dly_code, 8'hA5);
    tick(1);
    chk("R6 R11 commit at third edge", dly_code, 8'h96);
    tick(2);
    chk("R5 oe low after enable", sdo_oe, 0);

    // R8 clocks ignored while enable low
    for (int k = 0; k < 8; k++) pulse(1'b0);
    en_in = 1'b1;
    tick(4);
    for (int k = 0; k < 8; k++) begin
      chk("R8 reg kept under idle clocks", sdo, new_v[7-k]);
      pulse(new_v[7-k]);
    end
    en_in = 1'b0;
    tick(4);
    chk("R7 write-back keeps code", dly_code, 8'h96);

    // R9 two-device chain
    en_in = 1'b1;
    tick(4);
    old_v = 8'h3E; new_v = 8'hD1;
    for (int k = 0; k < 8; k++) pulse(old_v[7-k]);
    for (int k = 0; k < 8; k++) pulse(new_v[7-k]);
    en_in = 1'b0;
    tick(4);
    chk("R9 first device", dly_code, 8'hD1);
    chk("R9 second device", dly_code_b, 8'h3E);

    tick(2);
    done = 1'b1;
    report();
  end
endmodule